// File: doc/BRIEF.md
# PAM-4 Bang-Bang Phase Detector Logic

This block is the digital decision stage of a PAM-4 clock and data recovery loop. Each valid cycle it receives two Gray-coded symbols (one from each of two consecutive data sampling instants) and the edge-sampler bit taken between them. From these it issues single-cycle early or late pulses that drive a charge pump.

The block serves two phases of loop operation. Until the reference PLL reports frequency lock, the block stays silent and the PLL loop keeps control. After lock it issues phase decisions. The set of transitions it uses depends on threshold adaptation:

- While the edge threshold still sits at the data common mode, every symbol change counts.
- Once adaptation is flagged done, only swings that are symmetric about the common mode count, because only those cross at the eye centre.

Two saturating counters tally the early and late decisions so that loop behaviour can be observed.

Top module: `pam4_bbpd`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `p_up`, `p_dn`, `up_count` and `dn_count` to zero.
- R2: A cycle sampled with `freq_lock` low produces no pulse on `p_up` or `p_dn` in the following cycle, whatever the symbols.
- R3: Each symbol is decoded as {msb,lsb} 00→level 0, 01→1, 11→2, 10→3. When the previous and current levels are equal, neither output pulses.
- R4: With `adapt_done` low, every change of level qualifies for a phase decision, including minor one-level steps and two-level steps.
- R5: With `adapt_done` high, only level pairs summing to 3 (0↔3 and 1↔2) qualify. All other changes produce no pulse.
- R6: For a qualifying transition, `p_up` pulses when `edge_bit` equals `prev_msb`. Otherwise `p_dn` pulses. Exactly one of the two pulses.
- R7: Outputs are registered. A decision appears in the cycle after its inputs are sampled, lasts one cycle, and `p_up` and `p_dn` are never high together.
- R8: A cycle with `sym_valid` low produces no pulse in the following cycle.
- R9: `up_count` and `dn_count` increase by one in the cycle their pulse is high, hold otherwise, and saturate at 2^CNT_W-1 while pulses continue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sym_valid | input | 1 | Symbol pair and edge bit are valid this cycle |
| prev_msb | input | 1 | MSB of the earlier symbol |
| prev_lsb | input | 1 | LSB of the earlier symbol |
| cur_msb | input | 1 | MSB of the later symbol |
| cur_lsb | input | 1 | LSB of the later symbol |
| edge_bit | input | 1 | Edge-sampler decision between the two symbols |
| freq_lock | input | 1 | Reference PLL frequency lock reached |
| adapt_done | input | 1 | Threshold adaptation finished |
| p_up | output | 1 | Early pulse to charge pump |
| p_dn | output | 1 | Late pulse to charge pump |
| up_count | output | CNT_W | Saturating count of early decisions |
| dn_count | output | CNT_W | Saturating count of late decisions |

## Verification
Lock gating and the transition filter are both evaluated on the same cycle's inputs. The bench therefore applies a centre-crossing symbol pair in the very cycle `freq_lock` first rises, and again in the cycle it drops. It judges that the pulse appears only in the first case, one cycle later. The adaptation flag is also lowered in the same cycle as a minor step, to show that the wider filter takes effect immediately. Counter saturation is reached while pulses continue, so the bench confirms that the pulse and the frozen count coexist.

// File: rtl/pam4_bbpd.sv
module pam4_bbpd #(
  parameter int CNT_W  = 8,
  parameter bit CNT_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sym_valid,
  input  logic             prev_msb,
  input  logic             prev_lsb,
  input  logic             cur_msb,
  input  logic             cur_lsb,
  input  logic             edge_bit,
  input  logic             freq_lock,
  input  logic             adapt_done,
  output logic             p_up,
  output logic             p_dn,
  output logic [CNT_W-1:0] up_count,
  output logic [CNT_W-1:0] dn_count
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [1:0] lvl_prev, lvl_cur;
  logic [2:0] lvl_sum;
  logic       moved, centre, qualify, want_up, want_dn;

  assign lvl_prev = {prev_msb, prev_msb ^ prev_lsb};
  assign lvl_cur  = {cur_msb,  cur_msb  ^ cur_lsb};
  assign lvl_sum  = {1'b0, lvl_prev} + {1'b0, lvl_cur};
  assign moved    = lvl_prev != lvl_cur;
  assign centre   = lvl_sum == 3'd3;
  assign qualify  = sym_valid & freq_lock & moved & (~adapt_done | centre);
  assign want_up  = qualify & (edge_bit == prev_msb);
  assign want_dn  = qualify & (edge_bit != prev_msb);

  always_ff @(posedge clk) begin
    if (rst) begin
      p_up <= 1'b0;
      p_dn <= 1'b0;
    end else begin
      p_up <= want_up;
      p_dn <= want_dn;
    end
  end

  generate
    if (CNT_EN) begin : g_cnt
      always_ff @(posedge clk) begin
        if (rst) begin
          up_count <= '0;
          dn_count <= '0;
        end else begin
          if (want_up && up_count != CNT_MAX) up_count <= up_count + 1'b1;
          if (want_dn && dn_count != CNT_MAX) dn_count <= dn_count + 1'b1;
        end
      end
    end else begin : g_nocnt
      assign up_count = '0;
      assign dn_count = '0;
    end
  endgenerate

endmodule

module pam4_bbpd_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             sym_valid,
  input logic             prev_msb,
  input logic             prev_lsb,
  input logic             cur_msb,
  input logic             cur_lsb,
  input logic             freq_lock,
  input logic             adapt_done,
  input logic             p_up,
  input logic             p_dn,
  input logic [CNT_W-1:0] up_count,
  input logic [CNT_W-1:0] dn_count
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(p_up && p_dn));

  a_r2_lock_gate: assert property (@(posedge clk) disable iff (rst)
    !freq_lock |=> (!p_up && !p_dn));

  a_r8_valid_gate: assert property (@(posedge clk) disable iff (rst)
    !sym_valid |=> (!p_up && !p_dn));

  a_r3_no_change: assert property (@(posedge clk) disable iff (rst)
    (prev_msb == cur_msb && prev_lsb == cur_lsb) |=> (!p_up && !p_dn));

  // R5: in Gray code a centre swing flips the MSB and keeps the LSB
  a_r5_filter: assert property (@(posedge clk) disable iff (rst)
    (adapt_done && !(prev_msb != cur_msb && prev_lsb == cur_lsb)) |=> (!p_up && !p_dn));

  a_r9_up_step: assert property (@(posedge clk) disable iff (rst)
    (p_up && !$past(rst)) |->
      (up_count == $past(up_count) + 1'b1 || ($past(up_count) == CNT_MAX && up_count == CNT_MAX)));

  a_r9_up_hold: assert property (@(posedge clk) disable iff (rst)
    (!p_up && !$past(rst)) |-> $stable(up_count));

  a_r9_dn_step: assert property (@(posedge clk) disable iff (rst)
    (p_dn && !$past(rst)) |->
      (dn_count == $past(dn_count) + 1'b1 || ($past(dn_count) == CNT_MAX && dn_count == CNT_MAX)));

  a_r9_dn_hold: assert property (@(posedge clk) disable iff (rst)
    (!p_dn && !$past(rst)) |-> $stable(dn_count));

endmodule

bind pam4_bbpd pam4_bbpd_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .sym_valid(sym_valid),
  .prev_msb(prev_msb), .prev_lsb(prev_lsb), .cur_msb(cur_msb), .cur_lsb(cur_lsb),
  .freq_lock(freq_lock), .adapt_done(adapt_done),
  .p_up(p_up), .p_dn(p_dn), .up_count(up_count), .dn_count(dn_count)
);

// File: tb/tb_pam4_bbpd.sv
module tb_pam4_bbpd;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst, sym_valid, prev_msb, prev_lsb, cur_msb, cur_lsb, edge_bit, freq_lock, adapt_done;
  logic p_up, p_dn;
  logic [CW-1:0] up_count, dn_count;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pam4_bbpd #(.CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .sym_valid(sym_valid),
    .prev_msb(prev_msb), .prev_lsb(prev_lsb), .cur_msb(cur_msb), .cur_lsb(cur_lsb),
    .edge_bit(edge_bit), .freq_lock(freq_lock), .adapt_done(adapt_done),
    .p_up(p_up), .p_dn(p_dn), .up_count(up_count), .dn_count(dn_count)
  );

  // {lock, adapt, valid, pm, pl, cm, cl, edge, exp_up, exp_dn}
  localparam logic [9:0] VEC [16] = '{
    10'b0_0_1_00_10_0_00, // R2 no lock
    10'b1_0_1_00_10_0_10, // R4 R6 0->3 up
    10'b1_0_1_00_10_1_01, // R6 0->3 dn
    10'b1_0_1_00_01_0_10, // R4 minor 0->1 up
    10'b1_0_1_01_11_1_01, // R4 1->2 dn
    10'b1_0_1_11_11_0_00, // R3 no change
    10'b1_0_0_00_10_0_00, // R8 invalid
    10'b1_1_1_00_01_0_00, // R5 minor filtered
    10'b1_1_1_01_11_0_10, // R5 1->2 up
    10'b1_1_1_11_01_1_10, // R5 2->1 up
    10'b1_1_1_11_01_0_01, // R5 2->1 dn
    10'b1_1_1_10_00_1_10, // R5 3->0 up
    10'b1_1_1_10_01_0_00, // R5 3->1 filtered
    10'b1_1_1_00_11_0_00, // R5 0->2 filtered
    10'b1_1_1_11_10_1_00, // R5 2->3 filtered
    10'b1_0_1_10_00_0_01  // R4 3->0 dn
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [9:0] v, input string req);
    {freq_lock, adapt_done, sym_valid, prev_msb, prev_lsb, cur_msb, cur_lsb, edge_bit} = v[9:2];
    @(negedge clk);
    check(req, {30'd0, p_up, p_dn}, {30'd0, v[1:0]});
    sym_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #200000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    {freq_lock, adapt_done, sym_valid, prev_msb, prev_lsb, cur_msb, cur_lsb, edge_bit} = '0;
    repeat (3) @(negedge clk);
    check("R1 p_up", {31'd0, p_up}, 0);
    check("R1 p_dn", {31'd0, p_dn}, 0);
    check("R1 up_count", {29'd0, up_count}, 0);
    rst = 1'b0;

    for (int i = 0; i < 16; i++) apply(VEC[i], $sformatf("R6 vector %0d", i));
    check("R9 up_count", {29'd0, up_count}, 5);
    check("R9 dn_count", {29'd0, dn_count}, 4);

    // R7: the previous pulse must not linger
    @(negedge clk);
    check("R7 one-cycle pulse", {30'd0, p_up, p_dn}, 0);

    apply(10'b1_1_1_01_11_0_10, "R9 up to 6");
    check("R9 count 6", {29'd0, up_count}, 6);
    apply(10'b1_1_1_01_11_0_10, "R9 up to 7");
    check("R9 count 7", {29'd0, up_count}, 7);
    apply(10'b1_1_1_01_11_0_10, "R9 pulse at saturation");
    check("R9 saturated", {29'd0, up_count}, 7);
    check("R9 dn held", {29'd0, dn_count}, 4);

    // lock drop coinciding with centre swing, then lock rise with one
    apply(10'b0_1_1_00_10_0_00, "R2 lock drop");
    apply(10'b1_1_1_00_10_1_01, "R2 lock rise");
    // adaptation flag lowered in the same cycle as a minor step
    apply(10'b1_0_1_11_10_1_10, "R4 adapt falls");

    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 up_count after reset", {29'd0, up_count}, 0);
    check("R1 dn_count after reset", {29'd0, dn_count}, 0);
    rst = 1'b0;
    apply(10'b1_1_1_10_00_0_01, "R6 after reset");
    check("R9 dn after reset", {29'd0, dn_count}, 1);

    finish_run();
  end
endmodule